// File: doc/BRIEF.md
# Scheduled Square-Wave Pin Generator with Edge Capture

This block drives one shared pin, in one of two modes. In drive mode it makes a 50% duty square wave that is timed against an external free-running tick counter, `clk_time`. The host loads a 64-bit start time and a 32-bit half period, both counted in ticks, and then pulses `start_cmd`. The output goes high when the counter reaches the start time. After that it flips once every half period until `stop_cmd` is pulsed. Each new edge time is the previous scheduled edge plus the half period, so rounding error does not build up.

In sense mode the pin is an input and output drive is off. Every change of level, rising or falling, is passed through a synchroniser and then stamps the current counter value into a single 64-bit register. There is no queue behind that register, so a newer edge overwrites an older stamp.

Every port is a plain control or status pin, so the block has no valid/ready stream. The stamp register is a snapshot, and the host reads it whenever it chooses.

Top module: `sched_pin_gen`

## Requirements
- R1: After reset `pin_out` is 0, `sync_ts` is 0, `pin_oe` is 1 (drive mode with `capture_mode`=0) and the generator is disarmed.
- R2: A `start_cmd` pulse arms the generator only if `start_time` is strictly greater than the `clk_time` value sampled at that same clock edge. If `start_time` is equal to or less than that value, the pulse is ignored and `pin_out` stays 0.
- R3: Once armed, `pin_out` rises at the first clock edge where `clk_time` >= `start_time`. It then inverts at `start_time`+k*`half_period` for k = 1, 2, ..., and each output change is registered at the edge that samples that counter value.
- R4: A `start_cmd` pulse while `half_period` is 0 is ignored.
- R5: A `stop_cmd` pulse forces `pin_out` to 0 at the next edge and cancels a pending or running schedule. When both commands arrive in the same cycle, stop wins.
- R6: With `capture_mode`=1 (sense), `pin_oe` is 0, `pin_out` is forced to 0, the schedule is cancelled and `start_cmd` is ignored.
- R7: In sense mode, a level change of `pin_in` that is first sampled at clock edge k loads `sync_ts` with the `clk_time` seen at edge k+2 (two synchroniser flops plus edge detect). This applies to both rising and falling changes.
- R8: `sync_ts` keeps only the latest stamp, so a later edge overwrites it. In drive mode `pin_in` changes leave `sync_ts` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_time | input | 64 | Current tick count of the hardware clock |
| start_time | input | 64 | Tick at which toggling begins |
| half_period | input | 32 | Ticks between successive output edges |
| start_cmd | input | 1 | One-cycle start request |
| stop_cmd | input | 1 | One-cycle stop request |
| capture_mode | input | 1 | 0 = drive square wave, 1 = sense edges |
| pin_in | input | 1 | Asynchronous pin level in sense mode |
| pin_out | output | 1 | Square wave output |
| pin_oe | output | 1 | Output enable for the pin pad |
| sync_ts | output | 64 | Counter value at the most recent sensed edge |

## Verification
The cases that are hardest to reach from the ports are the boundary cycles: a start request whose start time equals the sampled counter value, a stop that arrives while a start is still pending, and two pin changes on consecutive cycles in sense mode. The bench drives the tick counter itself on the falling clock edge, so each command can be placed at an exact counter value. The scoreboard holds the expected time and level of every pin change. Any pin change that is not in the queue is reported, and this is how a schedule that should have been cancelled is caught.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic {
    PIN_DRIVE = 1'b0,
    PIN_SENSE = 1'b1
  } pin_fn_e;
endpackage

// File: rtl/spg_sync.sv
module spg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spg_wave.sv
module spg_wave #(
  parameter int TW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TW-1:0] now,
  input  logic [TW-1:0] start_at,
  input  logic [HW-1:0] half_per,
  input  logic          start_req,
  input  logic          stop_req,
  output logic          wave,
  output logic          armed
);
  logic [TW-1:0] next_edge;
  logic [HW-1:0] hp_q;
  logic          start_ok;
  logic          edge_due;

  // A start is accepted only for a future start tick and a non-zero half period
  assign start_ok = start_req && (half_per != '0) && (start_at > now);
  assign edge_due = armed && (now >= next_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      wave      <= 1'b0;
      next_edge <= '0;
      hp_q      <= '0;
    end else if (stop_req || !enable) begin
      armed <= 1'b0;
      wave  <= 1'b0;
    end else if (start_ok) begin
      armed     <= 1'b1;
      wave      <= 1'b0;
      next_edge <= start_at;
      hp_q      <= half_per;
    end else if (edge_due) begin
      wave      <= ~wave;
      // Advance from the scheduled edge, not from now, to avoid drift
      next_edge <= next_edge + TW'(hp_q);
    end
  end
endmodule

// File: rtl/spg_capture.sv
module spg_capture #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          level,
  input  logic [TW-1:0] now,
  output logic [TW-1:0] stamp
);
  logic prev_level;
  logic changed;

  assign changed = level ^ prev_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_level <= 1'b0;
      stamp      <= '0;
    end else begin
      prev_level <= level;
      if (enable && changed) stamp <= now;
    end
  end
endmodule

// File: rtl/sched_pin_gen.sv
module sched_pin_gen #(
  parameter int TIME_W      = 64,
  parameter int HP_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] clk_time,
  input  logic [TIME_W-1:0] start_time,
  input  logic [HP_W-1:0]   half_period,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              capture_mode,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic [TIME_W-1:0] sync_ts
);
  import spg_pkg::*;

  pin_fn_e pin_fn;
  logic    drive_en;
  logic    sense_en;
  logic    pin_sync;
  logic    gen_armed;

  assign pin_fn   = pin_fn_e'(capture_mode);
  assign drive_en = (pin_fn == PIN_DRIVE);
  assign sense_en = (pin_fn == PIN_SENSE);
  assign pin_oe   = drive_en;

  spg_wave #(.TW(TIME_W), .HW(HP_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (drive_en),
    .now       (clk_time),
    .start_at  (start_time),
    .half_per  (half_period),
    .start_req (start_cmd),
    .stop_req  (stop_cmd),
    .wave      (pin_out),
    .armed     (gen_armed)
  );

  spg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  spg_capture #(.TW(TIME_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (sense_en),
    .level  (pin_sync),
    .now    (clk_time),
    .stamp  (sync_ts)
  );
endmodule

// File: rtl/sched_pin_gen_chk.sv
module sched_pin_gen_chk #(
  parameter int TW = 64,
  parameter int HW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] clk_time,
  input logic [TW-1:0] start_time,
  input logic [HW-1:0] half_period,
  input logic          start_cmd,
  input logic          stop_cmd,
  input logic          capture_mode,
  input logic          pin_out,
  input logic [TW-1:0] sync_ts,
  input logic          armed
);
  // R5
  stop_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> (!pin_out && !armed));

  // R6
  sense_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_mode |=> (!pin_out && !armed));

  // R8
  drive_keeps_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!capture_mode) |-> $stable(sync_ts));

  // R3
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_out) |-> $past(armed && !stop_cmd && !capture_mode));

  // R2
  stale_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !armed && (start_time <= clk_time)) |=> !armed);

  // R4
  zero_half_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !armed && (half_period == '0)) |=> !armed);
endmodule

bind sched_pin_gen sched_pin_gen_chk #(.TW(TIME_W), .HW(HP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_time     (clk_time),
  .start_time   (start_time),
  .half_period  (half_period),
  .start_cmd    (start_cmd),
  .stop_cmd     (stop_cmd),
  .capture_mode (capture_mode),
  .pin_out      (pin_out),
  .sync_ts      (sync_ts),
  .armed        (gen_armed)
);

// File: tb/sched_pin_gen_bench.sv
`timescale 1ns/1ps
module sched_pin_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tm = '0;
  logic [63:0] start_time = '0;
  logic [31:0] half_period = '0;
  logic        start_cmd = 1'b0;
  logic        stop_cmd = 1'b0;
  logic        capture_mode = 1'b0;
  logic        pin_in = 1'b0;
  logic        pin_out;
  logic        pin_oe;
  logic [63:0] sync_ts;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] t;
    logic        lvl;
    string       rq;
  } ev_t;
  ev_t exp_q[$];
  logic last_pin = 1'b0;

  always #4 clk = ~clk;

  // Tick counter driven on the falling edge
  always @(negedge clk) tm <= tm + 64'd1;

  sched_pin_gen u_sched_pin_gen (
    .clk(clk), .rst_n(rst_n), .clk_time(tm), .start_time(start_time),
    .half_period(half_period), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .capture_mode(capture_mode), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .sync_ts(sync_ts)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Monitor: every change of pin_out must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && !done && (pin_out !== last_pin)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected pin change at tick", tm, 0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(tm == e.t, {e.rq, " edge tick"}, tm, e.t);
        chk(pin_out == e.lvl, {e.rq, " edge level"}, {63'd0, pin_out}, {63'd0, e.lvl});
      end
      last_pin = pin_out;
    end
  end

  // Wait until the next rising edge will sample tick t
  task automatic wait_tick(input logic [63:0] t);
    while (tm + 64'd1 != t) @(negedge clk);
  endtask

  task automatic do_start(input logic [63:0] at, input logic [63:0] s, input logic [31:0] h);
    wait_tick(at);
    start_time = s; half_period = h; start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
  endtask

  task automatic do_stop(input logic [63:0] at);
    wait_tick(at);
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
  endtask

  task automatic push(input logic [63:0] t, input logic lvl, input string rq);
    ev_t e;
    e.t = t; e.lvl = lvl; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    chk(1'b0, "watchdog expired", tm, 0);
    finish_up();
  end

  initial begin
    logic [63:0] p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pin_out == 1'b0, "R1 pin_out", {63'd0, pin_out}, 0);
    chk(sync_ts == 64'd0, "R1 sync_ts", sync_ts, 0);
    chk(pin_oe == 1'b1, "R1 pin_oe", {63'd0, pin_oe}, 1);

    // R3 basic wave, half period 5
    push(50, 1'b1, "R3"); push(55, 1'b0, "R3"); push(60, 1'b1, "R3"); push(65, 1'b0, "R3");
    do_start(20, 50, 5);
    do_stop(67);
    wait_tick(80);
    chk(exp_q.size() == 0, "R3 all edges seen", exp_q.size(), 0);
    chk(pin_out == 1'b0, "R5 low after stop", {63'd0, pin_out}, 0);

    // R3 half period 3, R5 stop while high
    push(120, 1'b1, "R3"); push(123, 1'b0, "R3"); push(126, 1'b1, "R3"); push(128, 1'b0, "R5");
    do_start(100, 120, 3);
    do_stop(128);
    wait_tick(140);
    chk(exp_q.size() == 0, "R5 stop edge seen", exp_q.size(), 0);

    // R2 start time equal to or behind the counter
    do_start(150, 150, 4);
    do_start(160, 140, 4);
    wait_tick(180);
    chk(pin_out == 1'b0, "R2 stale start ignored", {63'd0, pin_out}, 0);

    // R4 zero half period
    do_start(200, 220, 0);
    wait_tick(240);
    chk(pin_out == 1'b0, "R4 zero half period ignored", {63'd0, pin_out}, 0);

    // R5 stop cancels a pending start, and wins over a simultaneous start
    do_start(250, 300, 4);
    do_stop(260);
    wait_tick(320);
    chk(pin_out == 1'b0, "R5 pending start cancelled", {63'd0, pin_out}, 0);
    wait_tick(330);
    start_time = 340; half_period = 2; start_cmd = 1'b1; stop_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0; stop_cmd = 1'b0;
    wait_tick(360);
    chk(pin_out == 1'b0, "R5 stop wins over start", {63'd0, pin_out}, 0);

    // R8 drive mode ignores pin_in
    pin_in = 1'b1;
    repeat (6) @(negedge clk);
    chk(sync_ts == 64'd0, "R8 no stamp in drive mode", sync_ts, 0);

    // R6 switch to sense mode while running
    push(410, 1'b1, "R3"); push(411, 1'b0, "R6");
    do_start(400, 410, 2);
    wait_tick(411);
    capture_mode = 1'b1;
    @(negedge clk);
    chk(pin_oe == 1'b0, "R6 pin_oe off", {63'd0, pin_oe}, 0);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R6 forced low edge seen", exp_q.size(), 0);

    // R7 falling edge capture
    p = tm; pin_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(sync_ts == p + 64'd3, "R7 falling edge stamp", sync_ts, p + 64'd3);
    // R7 rising edge capture
    p = tm; pin_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(sync_ts == p + 64'd3, "R7 rising edge stamp", sync_ts, p + 64'd3);
    // R8 back-to-back edges, latest wins
    p = tm; pin_in = 1'b0;
    @(negedge clk);
    pin_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(sync_ts == p + 64'd4, "R8 overwrite by later edge", sync_ts, p + 64'd4);

    // R6 start ignored in sense mode
    do_start(tm + 2, tm + 10, 2);
    repeat (20) @(negedge clk);
    chk(pin_out == 1'b0, "R6 start ignored in sense mode", {63'd0, pin_out}, 0);

    capture_mode = 1'b0;
    @(negedge clk);
    chk(pin_oe == 1'b1, "R6 drive restored", {63'd0, pin_oe}, 1);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    finish_up();
  end
endmodule